// File: doc/BRIEF.md
# Forced-Link Qualification Filter

This block decides whether a serial link may be reported as up when autonegotiation is not driving that decision. That is the case when software has turned autonegotiation off, or when parallel detection has turned it off because the partner only sends idles. The block combines four things. The first is a gate on the optical signal-detect pin, which can be inverted and which is bypassed in SGMII mode. The second is a filter that requires sync status to be held continuously for a programmable interval, nominally 10 ms. The third keeps the link down while configuration codewords are arriving, until idles appear. The fourth is the parallel-detect decision that switches autonegotiation off and on.

While autonegotiation is active, the block follows the negotiation-complete input from the external negotiation state machine. Loss of sync or of the qualified signal detect always takes the link down in the same cycle. A force-transmit control opens the transmit-allow output whatever the link state is. Code-group decoding and the negotiation state machine itself sit outside this block.

Top module: `link_qual`

## Requirements
- R1: During and directly after reset, `link_up` is 0, the parallel-detect override is clear, so `an_active` equals `an_enable`, and `tx_allow` equals `force_tx`.
- R2: In fiber mode (`sgmii_mode`=0) with `sd_enable`=1, `link_up` is 0 whenever the qualified signal detect is inactive.
- R3: `sd_invert`=1 makes `sig_det_pin` active low, so the qualified detect is `sig_det_pin` XOR `sd_invert`.
- R4: With `sgmii_mode`=1, or with `sd_enable`=0, `sig_det_pin` has no effect on `link_up`.
- R5: With `stab_filter_en`=1 and autonegotiation inactive, `link_up` rises only once `sync_ok` has been sampled high on LIMIT consecutive clock edges. LIMIT is `STAB_CYCLES`, or `FAST_CYCLES` while `fast_timers`=1.
- R6: A single cycle with `sync_ok` low restarts the stability count from zero.
- R7: With `false_link_en`=1 and autonegotiation inactive, a cycle with `rx_cfg`=1 forces `link_up` to 0 from the next cycle. It stays 0 until a cycle with `rx_idle`=1 and `rx_cfg`=0, and `link_up` rises in the cycle after that.
- R8: With `pardet_en`=1, a cycle with `rx_idle`=1 and `rx_cfg`=0 clears `an_active` from the next cycle. A cycle with `rx_cfg`=1 restores `an_active`=`an_enable` from the next cycle, and config wins when both are seen. With `pardet_en`=0, the override clears on the next edge.
- R9: While `an_active`=1, `link_up` equals `an_done` AND `sync_ok` AND the qualified signal detect.
- R10: `link_up` falls in the same cycle that `sync_ok` or the qualified signal detect falls.
- R11: `tx_allow` is 1 whenever `force_tx`=1, and otherwise follows `link_up`.
- R12: With autonegotiation inactive and both filters off, `link_up` equals `sync_ok` AND the qualified signal detect, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_det_pin | input | 1 | Optical signal-detect pin |
| sync_ok | input | 1 | Receive synchronization status |
| rx_cfg | input | 1 | Config codeword received this cycle |
| rx_idle | input | 1 | Idle received this cycle |
| sgmii_mode | input | 1 | 1 = SGMII, 0 = fiber |
| an_enable | input | 1 | Software autonegotiation enable |
| an_done | input | 1 | Negotiation complete from external FSM |
| sd_enable | input | 1 | Require signal detect for link |
| sd_invert | input | 1 | Signal detect is active low |
| stab_filter_en | input | 1 | Enable sync stability filter |
| false_link_en | input | 1 | Suppress link while config words seen |
| pardet_en | input | 1 | Enable parallel detection |
| fast_timers | input | 1 | Use short test interval |
| force_tx | input | 1 | Allow transmit regardless of link |
| link_up | output | 1 | Link qualified up |
| an_active | output | 1 | Effective autonegotiation enable |
| tx_allow | output | 1 | Transmit permitted |

## Verification
A stability counter that is stuck or fails to clear would show as `link_up` rising too early, or never rising, at the exact edge where the consecutive-sync count reaches LIMIT. The bench therefore probes one cycle before and at that edge, with both the fast and the slow limit. A stale idle-seen or parallel-detect flag appears one cycle after the offending `rx_cfg` or `rx_idle` beat, as a wrong `link_up` or `an_active`. The combinational gate is swept over every combination of mode, enable, inversion, pin and sync.

// File: rtl/lq_pkg.sv
// Package: shared control struct and helper functions for the link
// qualification filter. Assumes nothing beyond plain integer parameters.
package lq_pkg;

    typedef struct packed {
        logic sd_enable;
        logic sd_invert;
        logic stab_filter_en;
        logic false_link_en;
        logic pardet_en;
        logic fast_timers;
    } lq_ctrl_t;

    // Larger of two interval lengths, used to size the stability counter.
    function automatic int unsigned lq_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lq_sd_gate.sv
// Module: signal-detect qualifier. Produces the qualified detect used by
// all link paths. Assumes sig_det_pin is already synchronized to clk.
module lq_sd_gate (
    input  logic sgmii_mode,
    input  logic sd_enable,
    input  logic sd_invert,
    input  logic sig_det_pin,
    output logic sd_qual
);
    // Detect is bypassed in SGMII mode or when not required; otherwise polarity-corrected pin.
    always_comb begin
        if (sgmii_mode || !sd_enable)
            sd_qual = 1'b1;
        else
            sd_qual = sig_det_pin ^ sd_invert;
    end
endmodule

// File: rtl/lq_stab_timer.sv
// Module: counts consecutive clock edges with sync_ok high and flags when
// the selected interval has been reached. Any low sync clears the count.
// Assumes FAST_CYCLES <= STAB_CYCLES is not required; counter sized for both.
module lq_stab_timer #(
    parameter int unsigned STAB_CYCLES = 1250000,
    parameter int unsigned FAST_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_ok,
    input  logic fast_timers,
    output logic stab_ok
);
    import lq_pkg::*;

    localparam int unsigned MAXC  = lq_max(STAB_CYCLES, FAST_CYCLES);
    localparam int unsigned CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Select the interval; a zero fast interval disables the override.
    generate
        if (FAST_CYCLES > 0) begin : g_fast
            always_comb limit = fast_timers ? CNT_W'(FAST_CYCLES) : CNT_W'(STAB_CYCLES);
        end else begin : g_nofast
            always_comb limit = CNT_W'(STAB_CYCLES);
        end
    endgenerate

    // Consecutive-sync counter, saturating at the active limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!sync_ok)
            cnt_q <= '0;
        else if (cnt_q < limit)
            cnt_q <= cnt_q + 1'b1;
    end

    // Interval reached.
    always_comb stab_ok = (cnt_q >= limit);
endmodule

// File: rtl/lq_pardet.sv
// Module: parallel-detect override. Remembers that the partner sends idles
// (autonegotiation should be off) until config words return.
module lq_pardet (
    input  logic clk,
    input  logic rst_n,
    input  logic pardet_en,
    input  logic rx_cfg,
    input  logic rx_idle,
    input  logic an_enable,
    output logic an_active
);
    logic an_off_q;

    // Override flag: config words win over idles; cleared when feature disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            an_off_q <= 1'b0;
        else if (!pardet_en)
            an_off_q <= 1'b0;
        else if (rx_cfg)
            an_off_q <= 1'b0;
        else if (rx_idle)
            an_off_q <= 1'b1;
    end

    // Effective autonegotiation enable.
    always_comb an_active = an_enable & ~an_off_q;
endmodule

// File: rtl/lq_idle_track.sv
// Module: remembers whether idles have been seen since the last config
// word or sync loss; used to suppress a false forced link.
module lq_idle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_ok,
    input  logic rx_cfg,
    input  logic rx_idle,
    output logic idle_seen
);
    logic seen_q;

    // Set by idles, cleared by config words or loss of sync.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (rx_cfg || !sync_ok)
            seen_q <= 1'b0;
        else if (rx_idle)
            seen_q <= 1'b1;
    end

    always_comb idle_seen = seen_q;
endmodule

// File: rtl/link_qual.sv
// Module: link qualification filter top. Combines the signal-detect gate,
// sync stability timer, idle tracker and parallel-detect override into the
// link_up decision. Assumes all inputs are synchronous to clk and that
// an_done comes from an external negotiation state machine.
module link_qual #(
    parameter int unsigned STAB_CYCLES = 1250000,
    parameter int unsigned FAST_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_det_pin,
    input  logic sync_ok,
    input  logic rx_cfg,
    input  logic rx_idle,
    input  logic sgmii_mode,
    input  logic an_enable,
    input  logic an_done,
    input  logic sd_enable,
    input  logic sd_invert,
    input  logic stab_filter_en,
    input  logic false_link_en,
    input  logic pardet_en,
    input  logic fast_timers,
    input  logic force_tx,
    output logic link_up,
    output logic an_active,
    output logic tx_allow
);
    import lq_pkg::*;

    lq_ctrl_t ctrl;
    logic     sd_qual;
    logic     stab_ok;
    logic     idle_seen;
    logic     forced_link;

    // Gather control bits into one struct.
    always_comb begin
        ctrl.sd_enable      = sd_enable;
        ctrl.sd_invert      = sd_invert;
        ctrl.stab_filter_en = stab_filter_en;
        ctrl.false_link_en  = false_link_en;
        ctrl.pardet_en      = pardet_en;
        ctrl.fast_timers    = fast_timers;
    end

    lq_sd_gate u_sd (
        .sgmii_mode  (sgmii_mode),
        .sd_enable   (ctrl.sd_enable),
        .sd_invert   (ctrl.sd_invert),
        .sig_det_pin (sig_det_pin),
        .sd_qual     (sd_qual)
    );

    lq_stab_timer #(
        .STAB_CYCLES (STAB_CYCLES),
        .FAST_CYCLES (FAST_CYCLES)
    ) u_stab (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_ok     (sync_ok),
        .fast_timers (ctrl.fast_timers),
        .stab_ok     (stab_ok)
    );

    lq_idle_track u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_ok   (sync_ok),
        .rx_cfg    (rx_cfg),
        .rx_idle   (rx_idle),
        .idle_seen (idle_seen)
    );

    lq_pardet u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pardet_en (ctrl.pardet_en),
        .rx_cfg    (rx_cfg),
        .rx_idle   (rx_idle),
        .an_enable (an_enable),
        .an_active (an_active)
    );

    // Forced-link path: raw conditions plus each optional filter.
    always_comb begin
        forced_link = sync_ok & sd_qual
                    & (~ctrl.stab_filter_en | stab_ok)
                    & (~ctrl.false_link_en  | idle_seen);
    end

    // Final link decision; held low in reset.
    always_comb begin
        if (!rst_n)
            link_up = 1'b0;
        else if (an_active)
            link_up = an_done & sync_ok & sd_qual;
        else
            link_up = forced_link;
    end

    // Transmit permission.
    always_comb tx_allow = link_up | force_tx;
endmodule

// File: rtl/link_qual_chk.sv
// Checker: temporal properties of link_qual, bound to every instance.
module link_qual_chk #(
    parameter int unsigned STAB_CYCLES = 1250000,
    parameter int unsigned FAST_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic sig_det_pin,
    input logic sync_ok,
    input logic rx_cfg,
    input logic rx_idle,
    input logic sgmii_mode,
    input logic an_enable,
    input logic sd_enable,
    input logic sd_invert,
    input logic stab_filter_en,
    input logic false_link_en,
    input logic pardet_en,
    input logic fast_timers,
    input logic force_tx,
    input logic link_up,
    input logic an_active,
    input logic tx_allow
);
    localparam int unsigned MAXC  = (STAB_CYCLES > FAST_CYCLES) ? STAB_CYCLES : FAST_CYCLES;
    localparam int unsigned RUN_W = $clog2(MAXC + 1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] lim;

    // Independent count of consecutive sync-high edges, saturating at the largest limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!sync_ok)
            run_q <= '0;
        else if (run_q < RUN_W'(MAXC))
            run_q <= run_q + 1'b1;
    end

    always_comb lim = (fast_timers && FAST_CYCLES > 0) ? RUN_W'(FAST_CYCLES) : RUN_W'(STAB_CYCLES);

    // R10: no link without sync.
    a_r10_sync_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |-> !link_up);

    // R2: fiber mode with inactive detect keeps link down.
    a_r2_sd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!sgmii_mode && sd_enable && (sig_det_pin == sd_invert)) |-> !link_up);

    // R5: filtered forced link needs a full stable interval.
    a_r5_stable_window: assert property (@(posedge clk) disable iff (!rst_n)
        (stab_filter_en && !an_active && link_up) |-> (run_q >= lim));

    // R7: config word blocks the forced link next cycle.
    a_r7_cfg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (false_link_en && rx_cfg && !an_active) |=> (an_active || !link_up));

    // R8: idles switch autonegotiation off.
    a_r8_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pardet_en && rx_idle && !rx_cfg) |=> !an_active);

    // R8: config words restore autonegotiation.
    a_r8_cfg_on: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cfg |=> (an_active == an_enable));

    // R11: force-transmit always opens transmit.
    a_r11_force_tx: assert property (@(posedge clk) disable iff (!rst_n)
        force_tx |-> tx_allow);
endmodule

bind link_qual link_qual_chk #(
    .STAB_CYCLES (STAB_CYCLES),
    .FAST_CYCLES (FAST_CYCLES)
) u_chk (.*);

// File: tb/link_qual_tb.sv
module link_qual_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STAB = 40;
    localparam int FAST = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic sig_det_pin = 0, sync_ok = 0, rx_cfg = 0, rx_idle = 0, sgmii_mode = 0;
    logic an_enable = 0, an_done = 0, sd_enable = 0, sd_invert = 0;
    logic stab_filter_en = 0, false_link_en = 0, pardet_en = 0, fast_timers = 0, force_tx = 0;
    logic link_up, an_active, tx_allow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_qual #(.STAB_CYCLES(STAB), .FAST_CYCLES(FAST)) u_dut (.*);

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        an_enable = 1;
        #1;
        chk(link_up, 0, "R1 link in reset");
        chk(tx_allow, 0, "R1 tx_allow in reset");
        tick(); tick();
        rst_n = 1;
        #1;
        chk(an_active, 1, "R1 an_active after reset");
        chk(link_up, 0, "R1 link after reset");
        an_enable = 0;

        // R2 R3 R4 R10 R12: exhaustive gate sweep
        for (int v = 0; v < 32; v++) begin
            logic exp;
            sgmii_mode  = v[0];
            sd_enable   = v[1];
            sd_invert   = v[2];
            sig_det_pin = v[3];
            sync_ok     = v[4];
            #1;
            exp = v[4] & (v[0] | ~v[1] | (v[3] ^ v[2]));
            chk(link_up, exp, "R2/R3/R4/R12 gate sweep");
        end
        sgmii_mode = 0; sd_enable = 0; sd_invert = 0; sig_det_pin = 0;

        // R5 R6: fast interval
        sync_ok = 0; tick();
        stab_filter_en = 1; fast_timers = 1; sync_ok = 1;
        for (int k = 1; k < FAST; k++) tick();
        chk(link_up, 0, "R5 fast one edge early");
        tick();
        chk(link_up, 1, "R5 fast at limit");
        sync_ok = 0; #1;
        chk(link_up, 0, "R10 immediate sync drop");
        tick();
        sync_ok = 1;
        for (int k = 1; k < FAST; k++) tick();
        chk(link_up, 0, "R6 restart early");
        tick();
        chk(link_up, 1, "R6 restart at limit");

        // R5: slow interval
        sync_ok = 0; fast_timers = 0; tick();
        sync_ok = 1;
        for (int k = 1; k < STAB; k++) tick();
        chk(link_up, 0, "R5 slow one edge early");
        tick();
        chk(link_up, 1, "R5 slow at limit");
        stab_filter_en = 0;

        // R7: false-link suppression
        false_link_en = 1; sync_ok = 0; tick(); sync_ok = 1; #1;
        chk(link_up, 0, "R7 no idles yet");
        rx_idle = 1; tick(); rx_idle = 0; #1;
        chk(link_up, 1, "R7 up after idle");
        rx_cfg = 1; #1;
        chk(link_up, 1, "R7 same cycle as cfg");
        tick(); rx_cfg = 0; tick(); tick();
        chk(link_up, 0, "R7 held down after cfg");
        rx_idle = 1; rx_cfg = 1; tick(); rx_idle = 0; rx_cfg = 0; #1;
        chk(link_up, 0, "R7 cfg wins over idle");
        rx_idle = 1; tick(); rx_idle = 0; #1;
        chk(link_up, 1, "R7 idle again");
        false_link_en = 0;

        // R8: parallel detection
        an_enable = 1; pardet_en = 1; #1;
        chk(an_active, 1, "R8 initial on");
        rx_idle = 1; tick(); rx_idle = 0; #1;
        chk(an_active, 0, "R8 idle turns off");
        rx_idle = 1; rx_cfg = 1; tick(); rx_idle = 0; rx_cfg = 0; #1;
        chk(an_active, 1, "R8 cfg wins");
        rx_idle = 1; tick(); rx_idle = 0; #1;
        chk(an_active, 0, "R8 off again");
        pardet_en = 0; tick();
        chk(an_active, 1, "R8 disable clears override");

        // R9: negotiated path
        an_done = 0; #1;
        chk(link_up, 0, "R9 not done");
        an_done = 1; #1;
        chk(link_up, 1, "R9 done");
        sd_enable = 1; sig_det_pin = 0; #1;
        chk(link_up, 0, "R9 detect low");
        sd_enable = 0; sync_ok = 0; #1;
        chk(link_up, 0, "R9 sync low");

        // R11: force transmit
        force_tx = 1; #1;
        chk(tx_allow, 1, "R11 forced with link down");
        force_tx = 0; #1;
        chk(tx_allow, 0, "R11 follows link down");
        sync_ok = 1; #1;
        chk(tx_allow, 1, "R11 follows link up");

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule